// File: doc/BRIEF.md
# Resize Coefficient Calculator

This block turns a pair of image dimensions per axis (source size and destination size, vertical and horizontal) into a single 32-bit control word for a pixel scaler. For each axis it first decides how many times the source must be halved before fine scaling, between zero and two times. It then computes a fixed-point step ratio with 13 fractional bits from the halved source size and the destination size, using a restoring divider that resolves one quotient bit per clock.

A caller presents the four sizes and pulses `start`. The block copies the sizes, works on the vertical axis and then on the horizontal axis, and raises `done` for one cycle. At that point either `ctrlWord` holds the packed result or `err` is high because one of the axes asks for a ratio the scaler cannot handle. The result stays put until the next accepted start.

Top module: `resize_coef_unit`

## Requirements
- R1: A source size above 4096 or a destination size above 1024, on either axis, ends the job with `err`=1.
- R2: A reduction steeper than 4:1 (destination*4 < source) ends the job with `err`=1. Exactly 4:1 is accepted.
- R3: A destination size of 0 or 1, or a source size of 0, ends the job with `err`=1.
- R4: The halving count per axis starts at 0. While the working size is above 1024 or at least twice the destination size, and the count is below 2, the working size is halved and the count goes up by one.
- R5: The ratio per axis is floor(8192*(working size - 1)/(destination size - 1)).
- R6: A ratio of 16384 or more is replaced by 0x3FFF.
- R7: The vertical halving count is placed in ctrlWord[31:30] and the vertical ratio in [29:16]. The horizontal halving count is placed in [15:14] and the horizontal ratio in [13:0].
- R8: The vertical axis is processed first. An error on either axis finishes the job with `err`=1 and `ctrlWord`=0.
- R9: `busy` is high from the cycle after an accepted start until `done`. `done` is high for exactly one cycle, with `busy` low. `start` is accepted only while `busy` is low, so a start during a job changes nothing. The sizes are captured at the accepted start. The result and `err` hold until the next accepted start, which clears both.
- R10: Reset clears `busy`, `done`, `err` and `ctrlWord`. This holds even when reset arrives in the middle of a job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a job with the sizes presented in this cycle |
| inHeight | input | 13 | Vertical source size |
| outHeight | input | 11 | Vertical destination size |
| inWidth | input | 13 | Horizontal source size |
| outWidth | input | 11 | Horizontal destination size |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last job was rejected |
| ctrlWord | output | 32 | Packed halving counts and ratios of both axes |

## Verification
The vector table gives the two axes different values, so a swapped or misplaced field shows up. Its cases cover:
- equal sizes, giving ratio 0x2000;
- an enlargement with a remainder, which exposes rounding;
- a halving forced only by the 1024 limit, and a halving forced by the 2x rule, which separate the two arms of the halving condition;
- an exact 2:1 ratio that must clamp;
- the 4096/1024 and exact 4:1 limits next to inputs one step past them.

Error vectors put the fault on the vertical axis alone or on the horizontal axis alone. Directed tests then cover:
- a second start during a job;
- result hold after `done`;
- clearing of a stale error by a good job;
- reset in the middle of a job.

// File: rtl/resize_coef_pkg.sv
package resize_coef_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic latch;      // capture sizes, clear result
    logic evalAxis;   // range check and divider load for current axis
    logic divStep;    // one restoring-division step
    logic storeAxis;  // write clamped ratio of current axis
    logic axisH;      // 0: vertical, 1: horizontal
  } rszStrobe_t;
endpackage

// File: rtl/resize_coef_ctrl.sv
module resize_coef_ctrl
  import resize_coef_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       axisErr,
  input  logic       divLast,
  output rszStrobe_t stb,
  output logic       busy,
  output logic       done
);
  typedef enum logic [2:0] {ST_IDLE, ST_CHECK, ST_DIV, ST_STORE, ST_FIN} state_t;
  state_t state;
  logic   axisHReg;
  logic   accept;

  assign accept = (state == ST_IDLE || state == ST_FIN) && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      axisHReg <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_FIN: begin
          if (accept) begin
            state    <= ST_CHECK;
            axisHReg <= 1'b0;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_CHECK: state <= axisErr ? ST_FIN : ST_DIV;
        ST_DIV:   if (divLast) state <= ST_STORE;
        ST_STORE: begin
          if (!axisHReg) begin
            axisHReg <= 1'b1;
            state    <= ST_CHECK;
          end else begin
            state <= ST_FIN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.latch     = accept;
    stb.evalAxis  = (state == ST_CHECK);
    stb.divStep   = (state == ST_DIV);
    stb.storeAxis = (state == ST_STORE);
    stb.axisH     = axisHReg;
  end

  assign busy = (state == ST_CHECK) || (state == ST_DIV) || (state == ST_STORE);
  assign done = (state == ST_FIN);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done || $past(start));
  // R9
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/resize_coef_dp.sv
module resize_coef_dp
  import resize_coef_pkg::*;
#(
  parameter int IN_W      = 13,
  parameter int OUT_W     = 11,
  parameter int MAX_IN    = 4096,
  parameter int MAX_OUT   = 1024,
  parameter int FRAC_BITS = 13,
  parameter int RATIO_W   = 14,
  parameter int DOWN_MAX  = 2,
  localparam int DOWN_W   = $clog2(DOWN_MAX + 1),
  localparam int FIELD_W  = DOWN_W + RATIO_W,
  localparam int WORD_W   = 2 * FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rszStrobe_t        stb,
  input  logic [IN_W-1:0]   inHeight,
  input  logic [OUT_W-1:0]  outHeight,
  input  logic [IN_W-1:0]   inWidth,
  input  logic [OUT_W-1:0]  outWidth,
  output logic              axisErr,
  output logic              divLast,
  output logic              err,
  output logic [WORD_W-1:0] ctrlWord
);
  localparam int DIVD_W = IN_W + FRAC_BITS;
  localparam int CNT_W  = $clog2(DIVD_W);
  localparam int REM_W  = OUT_W + 1;

  logic [IN_W-1:0]    inVReg, inHReg, curIn, work;
  logic [OUT_W-1:0]   outVReg, outHReg, curOut, divisorReg;
  logic [DOWN_W-1:0]  dnComb, dnReg;
  logic [DIVD_W-1:0]  quoReg;
  logic [REM_W-1:0]   remReg, shifted;
  logic [CNT_W-1:0]   stepCnt;
  logic [FIELD_W-1:0] vField, curField;
  logic [RATIO_W-1:0] ratio;
  logic               ovf, errReg;
  logic [WORD_W-1:0]  wordReg;

  assign curIn  = stb.axisH ? inHReg  : inVReg;
  assign curOut = stb.axisH ? outHReg : outVReg;

  // Range checks on the current axis, 32-bit arithmetic
  assign axisErr = (32'(curIn) > MAX_IN) || (32'(curOut) > MAX_OUT) ||
                   ((32'(curOut) << 2) < 32'(curIn)) ||
                   (curOut <= OUT_W'(1)) || (curIn == '0);

  // Pre-halving: at most DOWN_MAX steps
  always_comb begin
    work   = curIn;
    dnComb = '0;
    for (int k = 0; k < DOWN_MAX; k++) begin
      if ((32'(work) > MAX_OUT) || (32'(work) >= 32'(curOut) * 2)) begin
        work   = work >> 1;
        dnComb = dnComb + 1'b1;
      end
    end
  end

  assign shifted = {remReg[OUT_W-1:0], quoReg[DIVD_W-1]};
  assign divLast = (stepCnt == CNT_W'(DIVD_W - 1));
  assign ovf     = |quoReg[DIVD_W-1:RATIO_W];
  assign ratio   = ovf ? {RATIO_W{1'b1}} : quoReg[RATIO_W-1:0];
  assign curField = {dnReg, ratio};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inVReg <= '0; inHReg <= '0; outVReg <= '0; outHReg <= '0;
      divisorReg <= '0; dnReg <= '0; quoReg <= '0; remReg <= '0;
      stepCnt <= '0; vField <= '0; errReg <= 1'b0; wordReg <= '0;
    end else begin
      if (stb.latch) begin
        inVReg  <= inHeight;  outVReg <= outHeight;
        inHReg  <= inWidth;   outHReg <= outWidth;
        errReg  <= 1'b0;
        wordReg <= '0;
      end
      if (stb.evalAxis) begin
        if (axisErr) begin
          errReg <= 1'b1;
        end else begin
          quoReg     <= DIVD_W'(work - 1'b1) << FRAC_BITS;
          remReg     <= '0;
          divisorReg <= curOut - 1'b1;
          dnReg      <= dnComb;
          stepCnt    <= '0;
        end
      end
      if (stb.divStep) begin
        stepCnt <= stepCnt + 1'b1;
        if (shifted >= {1'b0, divisorReg}) begin
          remReg <= shifted - {1'b0, divisorReg};
          quoReg <= {quoReg[DIVD_W-2:0], 1'b1};
        end else begin
          remReg <= shifted;
          quoReg <= {quoReg[DIVD_W-2:0], 1'b0};
        end
      end
      if (stb.storeAxis) begin
        if (!stb.axisH) vField  <= curField;
        else            wordReg <= {vField, curField};
      end
    end
  end

  assign err      = errReg;
  assign ctrlWord = wordReg;

  // R5
  rem_below_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.divStep |=> remReg < {1'b0, divisorReg});
  // R4
  down_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.evalAxis && !axisErr |=> 32'(dnReg) <= DOWN_MAX);
endmodule

// File: rtl/resize_coef_unit.sv
module resize_coef_unit
  import resize_coef_pkg::*;
#(
  parameter int IN_W      = 13,
  parameter int OUT_W     = 11,
  parameter int MAX_IN    = 4096,
  parameter int MAX_OUT   = 1024,
  parameter int FRAC_BITS = 13,
  parameter int RATIO_W   = 14,
  parameter int DOWN_MAX  = 2,
  localparam int DOWN_W   = $clog2(DOWN_MAX + 1),
  localparam int WORD_W   = 2 * (DOWN_W + RATIO_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IN_W-1:0]   inHeight,
  input  logic [OUT_W-1:0]  outHeight,
  input  logic [IN_W-1:0]   inWidth,
  input  logic [OUT_W-1:0]  outWidth,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [WORD_W-1:0] ctrlWord
);
  rszStrobe_t stb;
  logic axisErr, divLast;

  resize_coef_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .axisErr(axisErr),
    .divLast(divLast), .stb(stb), .busy(busy), .done(done)
  );

  resize_coef_dp #(
    .IN_W(IN_W), .OUT_W(OUT_W), .MAX_IN(MAX_IN), .MAX_OUT(MAX_OUT),
    .FRAC_BITS(FRAC_BITS), .RATIO_W(RATIO_W), .DOWN_MAX(DOWN_MAX)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .inHeight(inHeight),
    .outHeight(outHeight), .inWidth(inWidth), .outWidth(outWidth),
    .axisErr(axisErr), .divLast(divLast), .err(err), .ctrlWord(ctrlWord)
  );

  // R8
  err_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && err |-> ctrlWord == '0);
  // R9
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(ctrlWord) && $stable(err));
endmodule

// File: tb/resize_coef_unit_test.sv
module resize_coef_unit_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [12:0] inHeight = '0, inWidth = '0;
  logic [10:0] outHeight = '0, outWidth = '0;
  logic busy, done, err;
  logic [31:0] ctrlWord;
  int nRun = 0, nFail = 0, cyc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  resize_coef_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .inHeight(inHeight),
    .outHeight(outHeight), .inWidth(inWidth), .outWidth(outWidth),
    .busy(busy), .done(done), .err(err), .ctrlWord(ctrlWord)
  );

  typedef struct packed {
    logic [12:0] iv; logic [10:0] ov; logic [12:0] ih; logic [10:0] oh;
    logic        e;  logic [31:0] w;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{13'd100,  11'd100,  13'd100, 11'd100,  1'b0, 32'h2000_2000}, // R5 R7 unity
    '{13'd4096, 11'd1024, 13'd199, 11'd100,  1'b0, 32'hA000_3FFF}, // R1 edge, R6 clamp
    '{13'd400,  11'd200,  13'd100, 11'd300,  1'b0, 32'h6000_0A98}, // R4 2x rule, R5 floor
    '{13'd1500, 11'd1000, 13'd100, 11'd100,  1'b0, 32'h57FD_2000}, // R4 1024 rule
    '{13'd800,  11'd200,  13'd100, 11'd100,  1'b0, 32'hA000_2000}, // R2 exact 4:1
    '{13'd801,  11'd200,  13'd100, 11'd100,  1'b1, 32'h0},         // R2 past 4:1
    '{13'd4097, 11'd1024, 13'd100, 11'd100,  1'b1, 32'h0},         // R1 source
    '{13'd100,  11'd100,  13'd100, 11'd1025, 1'b1, 32'h0},         // R1 dest, R8 late error
    '{13'd100,  11'd1,    13'd100, 11'd100,  1'b1, 32'h0},         // R3 dest 1
    '{13'd100,  11'd100,  13'd0,   11'd100,  1'b1, 32'h0}          // R3 source 0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  task automatic drive(input vec_t v);
    inHeight = v.iv; outHeight = v.ov; inWidth = v.ih; outWidth = v.oh;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
    if (!ok) begin nRun++; nFail++; $display("FAIL R9 done timeout actual=0 expected=1"); end
  endtask

  task automatic run_vec(input vec_t v, input string req);
    bit ok;
    @(negedge clk); drive(v); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R9 busy after start", {31'b0, busy}, 32'd1);
    wait_done(ok);
    if (ok) begin
      check({req, " err"}, {31'b0, err}, {31'b0, v.e});
      check({req, " word"}, ctrlWord, v.w);
      check("R9 busy low at done", {31'b0, busy}, 32'd0);
      @(negedge clk);
      check("R9 done one cycle", {31'b0, done}, 32'd0);
      check("R9 word held", ctrlWord, v.w);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 busy", {31'b0, busy}, 32'd0);
    check("R10 done", {31'b0, done}, 32'd0);
    check("R10 err", {31'b0, err}, 32'd0);
    check("R10 word", ctrlWord, 32'd0);
    rst_n = 1'b1;

    foreach (VECS[i]) run_vec(VECS[i], $sformatf("vec%0d", i));

    // R9: a good job after an error clears err
    run_vec(VECS[0], "R9 err cleared");

    // R9: start during a job is ignored and inputs are captured at start
    @(negedge clk); drive(VECS[2]); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    drive(VECS[1]); start = 1'b1;
    @(negedge clk); start = 1'b0; drive(VECS[3]);
    wait_done(ok);
    if (ok) check("R9 start ignored while busy", ctrlWord, VECS[2].w);
    repeat (10) @(negedge clk);
    check("R9 result held idle", ctrlWord, VECS[2].w);

    // R10: reset during a job
    drive(VECS[0]); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (8) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 busy mid-job", {31'b0, busy}, 32'd0);
    check("R10 word mid-job", ctrlWord, 32'd0);
    check("R10 done mid-job", {31'b0, done}, 32'd0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    check("R10 stays idle", {31'b0, busy}, 32'd0);

    finish_run();
  end
endmodule